// File: doc/BRIEF.md
# Windowed Pixel Luminance Histogram

This block measures the brightness distribution of each video frame. For every valid RGB pixel it forms a weighted luminance from three programmable weights. It maps that value to a histogram bin whose width is either fixed by software or derived from an aggressiveness level. It then increments the matching bin counter. The count can be limited to pixels inside a programmable rectangle.

At each frame boundary the finished histogram is frozen and the next frame accumulates into a second counter set. A downstream gain controller reads the frozen counts through a combinational read port after the one-cycle `frame_done` strobe. The boundary comes from either the main vertical pulse or an alternate vertical pulse.

Top module: `luma_hist`

## Requirements
- R1: A pixel is counted only in a cycle where `pix_valid` is 1. A cycle with `pix_valid` at 0 changes no bin.
- R2: The three weights sit in `luma_wts`: blue in bits [4:0], green in bits [9:5] and red in bits [14:10]. Luminance is (R*red + G*green + B*blue) shifted right by 4. A result above 255 is clamped to 255. With weights blue 5, green 9 and red 2, a pixel of all 255 gives 255.
- R3: `bw_code` values 0, 1, 2 and 3 select bin widths of 1, 2, 4 and 8 levels. The bin index is luminance divided by the width, clamped to 31 (32 bins). Codes 4 to 6 act as their two low bits.
- R4: `bw_code` 7 selects the width from `aggr_lvl`. Levels 0, 1 and 2 give width 8, level 3 gives 4, level 4 gives 2, and level 5 or above gives 1.
- R5: When `win_en` is 1, a pixel is counted only if `win_x0 <= pix_x <= win_x1` and `win_y0 <= pix_y <= win_y1`. Both edges are inclusive.
- R6: The counts of a completed frame stay on the read port, unchanged by the pixels of the following frame, until the next boundary.
- R7: A boundary pulse presented in cycle N raises `frame_done` for one cycle after the second rising edge. In that cycle `rd_count` already shows the completed frame. A pixel presented together with the boundary pulse belongs to the new frame.
- R8: With `alt_trig_en` at 1, only `alt_vpulse` ends a frame. With it at 0, only `vsync_pulse` ends a frame. The unselected pulse has no effect.
- R9: A bin counter stops at 2^CNT_W-1 and does not wrap.
- R10: After reset both counter sets read 0 and `frame_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_r | input | CW | Red component |
| pix_g | input | CW | Green component |
| pix_b | input | CW | Blue component |
| pix_x | input | XW | Pixel column |
| pix_y | input | XW | Pixel row |
| vsync_pulse | input | 1 | Main vertical frame pulse |
| alt_vpulse | input | 1 | Alternate vertical frame pulse |
| alt_trig_en | input | 1 | 1 selects the alternate pulse as the frame boundary |
| luma_wts | input | 3*CFW | Weights: blue [4:0], green [9:5], red [14:10] |
| bw_code | input | 3 | Bin width code, 7 = automatic |
| aggr_lvl | input | AGW | Aggressiveness level for automatic width |
| win_en | input | 1 | Restrict counting to the window |
| win_x0 | input | XW | Window left column, inclusive |
| win_x1 | input | XW | Window right column, inclusive |
| win_y0 | input | XW | Window top row, inclusive |
| win_y1 | input | XW | Window bottom row, inclusive |
| rd_bin | input | BIN_IW | Bin index to read from the frozen set |
| rd_count | output | CNT_W | Frozen count of bin `rd_bin` |
| frame_done | output | 1 | One-cycle strobe: a new frozen histogram is readable |

## Verification
Most internal errors in this block surface only at the next boundary. A wrong weight field, bin shift, window edge or saturation limit leaves `frame_done` on time but puts a count in the wrong bin. Comparing every bin of every frozen frame therefore exposes them within one frame. A fault in bank selection or clearing shows as counts carried over from an earlier frame, or as values that move on the read port while a new frame fills. Re-reading a frozen set after more pixels catches this. A fault in trigger selection shows as a missing or extra `frame_done` two cycles after the offending pulse.

// File: rtl/luma_hist_pkg.sv
package luma_hist_pkg;

  localparam logic [2:0] BW_AUTO = 3'd7;

  // shift amount (log2 of bin width) chosen from an aggressiveness level
  function automatic logic [1:0] auto_shift(input int unsigned lvl);
    logic [1:0] sh;
    if (lvl <= 2)       sh = 2'd3;
    else if (lvl == 3)  sh = 2'd2;
    else if (lvl == 4)  sh = 2'd1;
    else                sh = 2'd0;
    return sh;
  endfunction

endpackage

// File: rtl/luma_hist_front.sv
module luma_hist_front
  import luma_hist_pkg::*;
#(
  parameter int CW     = 8,
  parameter int CFW    = 5,
  parameter int XW     = 12,
  parameter int AGW    = 3,
  parameter int NBINS  = 32,
  localparam int BIN_IW = $clog2(NBINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic [CW-1:0]      pix_r,
  input  logic [CW-1:0]      pix_g,
  input  logic [CW-1:0]      pix_b,
  input  logic [XW-1:0]      pix_x,
  input  logic [XW-1:0]      pix_y,
  input  logic               vsync_pulse,
  input  logic               alt_vpulse,
  input  logic               alt_trig_en,
  input  logic [3*CFW-1:0]   luma_wts,
  input  logic [2:0]         bw_code,
  input  logic [AGW-1:0]     aggr_lvl,
  input  logic               win_en,
  input  logic [XW-1:0]      win_x0,
  input  logic [XW-1:0]      win_x1,
  input  logic [XW-1:0]      win_y0,
  input  logic [XW-1:0]      win_y1,
  output logic               hit_q,
  output logic [BIN_IW-1:0]  bin_q,
  output logic               bnd_q
);

  localparam int SUM_W = CW + CFW + 2;
  localparam logic [SUM_W-1:0] LUMA_MAX = SUM_W'((1 << CW) - 1);
  localparam logic [CW-1:0]    BIN_MAX  = CW'(NBINS - 1);

  function automatic logic [CW-1:0] weigh(
    input logic [CW-1:0] r, input logic [CW-1:0] g, input logic [CW-1:0] b,
    input logic [3*CFW-1:0] w);
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] scaled;
    acc = SUM_W'(r) * SUM_W'(w[3*CFW-1:2*CFW])
        + SUM_W'(g) * SUM_W'(w[2*CFW-1:CFW])
        + SUM_W'(b) * SUM_W'(w[CFW-1:0]);
    scaled = acc >> 4;
    return (scaled > LUMA_MAX) ? {CW{1'b1}} : scaled[CW-1:0];
  endfunction

  function automatic logic [BIN_IW-1:0] pick_bin(input logic [CW-1:0] l,
                                                 input logic [1:0] sh);
    logic [CW-1:0] q;
    q = l >> sh;
    return (q > BIN_MAX) ? BIN_MAX[BIN_IW-1:0] : q[BIN_IW-1:0];
  endfunction

  logic [CW-1:0]     luma_c;
  logic [1:0]        shift_c;
  logic              inside_c;
  logic              count_c;
  logic              trig_c;
  logic [BIN_IW-1:0] bin_c;

  assign luma_c   = weigh(pix_r, pix_g, pix_b, luma_wts);
  assign shift_c  = (bw_code == BW_AUTO) ? auto_shift(int'(aggr_lvl)) : bw_code[1:0];
  assign bin_c    = pick_bin(luma_c, shift_c);
  assign inside_c = (pix_x >= win_x0) && (pix_x <= win_x1) &&
                    (pix_y >= win_y0) && (pix_y <= win_y1);
  assign count_c  = pix_valid && (!win_en || inside_c);
  assign trig_c   = alt_trig_en ? alt_vpulse : vsync_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      bin_q <= '0;
      bnd_q <= 1'b0;
    end else begin
      hit_q <= count_c;
      bin_q <= bin_c;
      bnd_q <= trig_c;
    end
  end

endmodule

// File: rtl/luma_hist_bank.sv
module luma_hist_bank #(
  parameter int NBINS  = 32,
  parameter int CNT_W  = 16,
  localparam int BIN_IW = $clog2(NBINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [BIN_IW-1:0] bin,
  input  logic              bnd,
  input  logic [BIN_IW-1:0] rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic              frame_done
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // 0: set A accumulates, set B frozen; 1: the reverse
  logic                   acc_sel;
  logic [NBINS*CNT_W-1:0] flat_a;
  logic [NBINS*CNT_W-1:0] flat_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_sel    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= bnd;
      if (bnd) acc_sel <= ~acc_sel;
    end
  end

  for (genvar i = 0; i < NBINS; i++) begin : g_bin
    logic             inc;
    logic [CNT_W-1:0] cnt_a;
    logic [CNT_W-1:0] cnt_b;

    assign inc = hit && (bin == BIN_IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_a <= '0;
        cnt_b <= '0;
      end else if (bnd) begin
        // set that starts accumulating is cleared, seeded by a coincident pixel
        if (acc_sel) cnt_a <= CNT_W'(inc);
        else         cnt_b <= CNT_W'(inc);
      end else if (inc) begin
        if (!acc_sel && cnt_a != CNT_MAX) cnt_a <= cnt_a + 1'b1;
        if ( acc_sel && cnt_b != CNT_MAX) cnt_b <= cnt_b + 1'b1;
      end
    end

    assign flat_a[i*CNT_W +: CNT_W] = cnt_a;
    assign flat_b[i*CNT_W +: CNT_W] = cnt_b;
  end

  assign rd_count = acc_sel ? flat_a[rd_bin*CNT_W +: CNT_W]
                            : flat_b[rd_bin*CNT_W +: CNT_W];

endmodule

// File: rtl/luma_hist.sv
module luma_hist #(
  parameter int CW     = 8,
  parameter int CFW    = 5,
  parameter int XW     = 12,
  parameter int AGW    = 3,
  parameter int NBINS  = 32,
  parameter int CNT_W  = 16,
  localparam int BIN_IW = $clog2(NBINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [CW-1:0]     pix_r,
  input  logic [CW-1:0]     pix_g,
  input  logic [CW-1:0]     pix_b,
  input  logic [XW-1:0]     pix_x,
  input  logic [XW-1:0]     pix_y,
  input  logic              vsync_pulse,
  input  logic              alt_vpulse,
  input  logic              alt_trig_en,
  input  logic [3*CFW-1:0]  luma_wts,
  input  logic [2:0]        bw_code,
  input  logic [AGW-1:0]    aggr_lvl,
  input  logic              win_en,
  input  logic [XW-1:0]     win_x0,
  input  logic [XW-1:0]     win_x1,
  input  logic [XW-1:0]     win_y0,
  input  logic [XW-1:0]     win_y1,
  input  logic [BIN_IW-1:0] rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic              frame_done
);

  // named internal events for the checker
  logic              hit_s1;
  logic [BIN_IW-1:0] bin_s1;
  logic              bnd_s1;

  luma_hist_front #(
    .CW(CW), .CFW(CFW), .XW(XW), .AGW(AGW), .NBINS(NBINS)
  ) u_front (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_x(pix_x), .pix_y(pix_y),
    .vsync_pulse(vsync_pulse), .alt_vpulse(alt_vpulse), .alt_trig_en(alt_trig_en),
    .luma_wts(luma_wts), .bw_code(bw_code), .aggr_lvl(aggr_lvl),
    .win_en(win_en), .win_x0(win_x0), .win_x1(win_x1),
    .win_y0(win_y0), .win_y1(win_y1),
    .hit_q(hit_s1), .bin_q(bin_s1), .bnd_q(bnd_s1)
  );

  luma_hist_bank #(
    .NBINS(NBINS), .CNT_W(CNT_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .hit(hit_s1), .bin(bin_s1), .bnd(bnd_s1),
    .rd_bin(rd_bin), .rd_count(rd_count), .frame_done(frame_done)
  );

endmodule

// File: rtl/luma_hist_chk.sv
module luma_hist_chk #(
  parameter int XW     = 12,
  parameter int BIN_IW = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [XW-1:0]     pix_x,
  input logic              win_en,
  input logic [XW-1:0]     win_x0,
  input logic              vsync_pulse,
  input logic              alt_vpulse,
  input logic              alt_trig_en,
  input logic [BIN_IW-1:0] rd_bin,
  input logic [CNT_W-1:0]  rd_count,
  input logic              frame_done,
  input logic              hit_s1,
  input logic              bnd_s1
);

  // R1
  invalid_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !hit_s1);

  // R5
  left_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && win_en && (pix_x < win_x0)) |=> !hit_s1);

  // R6
  frozen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && $stable(rd_bin)) |-> $stable(rd_count));

  // R7
  main_pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_trig_en && vsync_pulse) |-> ##2 frame_done);

  // R8
  alt_pulse_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_trig_en && alt_vpulse) |-> ##2 frame_done);

  // R8
  unselected_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_trig_en && vsync_pulse && !alt_vpulse) |=> !bnd_s1);

endmodule

bind luma_hist luma_hist_chk #(
  .XW(XW), .BIN_IW(BIN_IW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
  .win_en(win_en), .win_x0(win_x0), .vsync_pulse(vsync_pulse),
  .alt_vpulse(alt_vpulse), .alt_trig_en(alt_trig_en), .rd_bin(rd_bin),
  .rd_count(rd_count), .frame_done(frame_done), .hit_s1(hit_s1), .bnd_s1(bnd_s1)
);

// File: tb/luma_hist_bench.sv
module luma_hist_bench;

  localparam int NB   = 32;
  localparam int CNTW = 6;
  localparam int SAT  = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic        vsync_pulse = 1'b0, alt_vpulse = 1'b0, alt_trig_en = 1'b0;
  logic [14:0] luma_wts = '0;
  logic [2:0]  bw_code = '0;
  logic [2:0]  aggr_lvl = '0;
  logic        win_en = 1'b0;
  logic [11:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
  logic [4:0]  rd_bin = '0;
  logic [5:0]  rd_count;
  logic        frame_done;

  always #10ns clk = ~clk;

  luma_hist #(.CNT_W(CNTW)) u_luma_hist (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_x(pix_x), .pix_y(pix_y),
    .vsync_pulse(vsync_pulse), .alt_vpulse(alt_vpulse), .alt_trig_en(alt_trig_en),
    .luma_wts(luma_wts), .bw_code(bw_code), .aggr_lvl(aggr_lvl),
    .win_en(win_en), .win_x0(win_x0), .win_x1(win_x1),
    .win_y0(win_y0), .win_y1(win_y1),
    .rd_bin(rd_bin), .rd_count(rd_count), .frame_done(frame_done)
  );

  int nvec = 0;
  int nfail = 0;
  int exp_q[$];
  string tag_q[$];
  int exp_h[NB];
  int last_h[NB];
  bit mon_busy = 0;
  bit reread_req = 0;

  // bench configuration mirrored into the model
  int wb = 5, wg = 9, wr = 2;
  int code = 0, aggr = 0;
  bit wen = 0;
  int wx0 = 0, wx1 = 0, wy0 = 0, wy1 = 0;

  function automatic int model_luma(int r, int g, int b);
    int t;
    t = (wr * r + wg * g + wb * b) / 16;   // R2
    return (t > 255) ? 255 : t;
  endfunction

  function automatic int model_bin(int l);
    int w;
    if (code == 7) begin                   // R4
      if (aggr <= 2)      w = 8;
      else if (aggr == 3) w = 4;
      else if (aggr == 4) w = 2;
      else                w = 1;
    end else begin                         // R3
      w = 1 << (code % 4);
    end
    return (l / w > NB - 1) ? NB - 1 : l / w;
  endfunction

  task automatic px(input int r, input int g, input int b,
                    input int x = 0, input int y = 0, input bit v = 1);
    int bn;
    @(negedge clk);
    pix_valid = v;
    pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    pix_x = 12'(x); pix_y = 12'(y);
    luma_wts = {5'(wr), 5'(wg), 5'(wb)};
    bw_code = 3'(code); aggr_lvl = 3'(aggr);
    win_en = wen;
    win_x0 = 12'(wx0); win_x1 = 12'(wx1); win_y0 = 12'(wy0); win_y1 = 12'(wy1);
    if (v && (!wen || (x >= wx0 && x <= wx1 && y >= wy0 && y <= wy1))) begin
      bn = model_bin(model_luma(r, g, b));
      if (exp_h[bn] < SAT) exp_h[bn]++;   // R9
    end
  endtask

  task automatic end_frame(input string tag);
    @(negedge clk);
    pix_valid = 1'b0;
    if (alt_trig_en) alt_vpulse = 1'b1; else vsync_pulse = 1'b1;
    for (int b = 0; b < NB; b++) begin
      exp_q.push_back(exp_h[b]);
      last_h[b] = exp_h[b];
      exp_h[b] = 0;
    end
    tag_q.push_back(tag);
    @(negedge clk);
    vsync_pulse = 1'b0; alt_vpulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wait (!mon_busy);
  endtask

  // R8: pulse on the line that is not selected
  task automatic pulse_unselected();
    @(negedge clk);
    pix_valid = 1'b0;
    if (alt_trig_en) vsync_pulse = 1'b1; else alt_vpulse = 1'b1;
    @(negedge clk);
    vsync_pulse = 1'b0; alt_vpulse = 1'b0;
    repeat (3) @(negedge clk);
    wait (!mon_busy);
  endtask

  // R6: re-read the frozen set after more pixels
  task automatic reread(input string tag);
    for (int b = 0; b < NB; b++) exp_q.push_back(last_h[b]);
    tag_q.push_back(tag);
    @(posedge clk);
    reread_req = 1'b1;
    @(negedge clk);
    #2ns reread_req = 1'b0;
    wait (!mon_busy);
  endtask

  // monitor: pops expected counts and compares the frozen histogram
  initial begin
    string t;
    int e;
    forever begin
      @(negedge clk);
      if (rst_n && (frame_done || reread_req)) begin
        mon_busy = 1'b1;
        if (tag_q.size() == 0) begin
          nvec++; nfail++;
          $display("FAIL R8 unexpected frame_done: actual 1 expected 0");
        end else begin
          t = tag_q.pop_front();
          for (int b = 0; b < NB; b++) begin
            rd_bin = 5'(b);
            #1ns;
            e = exp_q.pop_front();
            nvec++;
            if (int'(rd_count) != e) begin
              nfail++;
              $display("FAIL %s bin %0d: actual %0d expected %0d", t, b, rd_count, e);
            end
            if (b < NB - 1) @(negedge clk);
          end
        end
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) exp_h[b] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    nvec++;
    if (frame_done !== 1'b0) begin
      nfail++; $display("FAIL R10 frame_done: actual %0b expected 0", frame_done);
    end
    for (int b = 0; b < NB; b += 31) begin
      rd_bin = 5'(b); #1ns; nvec++;
      if (rd_count !== '0) begin
        nfail++; $display("FAIL R10 bin %0d: actual %0d expected 0", b, rd_count);
      end
    end

    // frame 1: example weights, width 1, one invalid pixel
    wb = 5; wg = 9; wr = 2; code = 0;
    px(0, 0, 0); px(16, 16, 16); px(255, 0, 0); px(0, 0, 255);
    px(0, 20, 0); px(16, 16, 16); px(255, 255, 255, 0, 0, 0);
    end_frame("R1 R2 R3 R7 width1");

    // frame 2: width 8, white pixel lands in 31
    code = 3;
    px(255, 255, 255); px(100, 100, 100); px(40, 40, 40); px(8, 8, 8);
    end_frame("R2 R3 width8");

    // frame 3: red-only weight, width 4, plus saturated luma
    wb = 0; wg = 0; wr = 16; code = 2;
    px(3, 0, 0); px(4, 0, 0); px(127, 0, 0); px(60, 200, 200);
    wb = 31; wg = 31; wr = 31; code = 1;
    px(255, 255, 255); px(10, 10, 10);
    end_frame("R2 R3 width4 width2 clamp");

    // frame 4: automatic width across levels
    wb = 5; wg = 9; wr = 2; code = 7;
    for (int a = 0; a < 8; a++) begin
      aggr = a;
      px(40, 40, 40); px(7, 7, 7);
    end
    end_frame("R4 auto");

    // frame 5: window edges
    code = 0; aggr = 0; wen = 1; wx0 = 10; wx1 = 20; wy0 = 5; wy1 = 8;
    px(3, 3, 3, 10, 5); px(4, 4, 4, 20, 8); px(5, 5, 5, 9, 5);
    px(6, 6, 6, 21, 6); px(7, 7, 7, 15, 4); px(8, 8, 8, 15, 9);
    px(9, 9, 9, 15, 6);
    end_frame("R5 window");
    wen = 0;

    // frame 6: alternate trigger, main pulse ignored
    alt_trig_en = 1'b1;
    px(1, 1, 1); px(2, 2, 2);
    pulse_unselected();
    px(3, 3, 3);
    end_frame("R8 alt trigger");
    px(5, 5, 5);
    alt_trig_en = 1'b0;
    pulse_unselected();
    end_frame("R8 main trigger");

    // frame 7: counter saturation
    for (int k = 0; k < 70; k++) px(30, 30, 30);
    for (int k = 0; k < 5; k++) px(12, 12, 12);
    end_frame("R9 saturation");

    // frozen set unchanged by following pixels
    for (int k = 0; k < 10; k++) px(30, 30, 30);
    px(12, 12, 12); px(2, 2, 2);
    reread("R6 frozen");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule